// File: doc/BRIEF.md
# Paged Windowed Register File

This block is a byte-wide register file of 256 addresses that translates three kinds of reference before it touches storage. The lower 224 addresses and the 16 system registers above them are held in one flat array. The top 16 addresses form a window into a separate paged store, and the page shown there is set by a page register. That page register is an ordinary system register inside the file, at address 234. Because it keeps its value until it is written again, a run of accesses to one page needs only one page selection.

Both the read port and the write port accept either an absolute 8-bit address or a short 4-bit working index. A working index is relocated through two block pointers, each counting in units of 8 bytes. In single mode, all 16 indices form one 16-byte-aligned block. In dual mode, indices 0 to 7 and 8 to 15 each sit in their own 8-byte-aligned block. Reads are combinational and writes take effect on the clock edge, so a core can read and write in the same cycle.

Top module: `paged_regfile`

## Requirements
- R1: After reset, every flat and paged location reads as zero, both block pointers are 0 and the page register (address 234) is 0.
- R2: An absolute address from 0 to 239 selects one fixed flat location. A value written there reads back on the next cycle.
- R3: In single mode (`dual_mode`=0), working index x maps to absolute address 16*floor(P0/2)+x, where P0 is the first block pointer. The low bit of P0 is ignored.
- R4: In dual mode (`dual_mode`=1), index x from 0 to 7 maps to 8*P0+x, and index x from 8 to 15 maps to 8*P1+(x-8).
- R5: A pulse on `ptr_we` loads `ptr_blk` into P0 when `ptr_sel`=0 and into P1 when `ptr_sel`=1. With `ptr_we` low, both pointers hold their values.
- R6: Addresses 224 to 239 are never banked. Their contents read the same whatever page is selected.
- R7: The low 6 bits of address 234 give the page number. Address 240+k reaches entry k of that page, so page 5 with address 242 reaches entry 2 of page 5. Address 234 reads back as written.
- R8: A write to address 234 changes the page seen by the window from the next cycle onward. A read of the window in the same cycle still uses the previous page. Otherwise the page does not change.
- R9: Only pages 0 to NPAGE-1 exist (NPAGE=16 by default). With a higher page number selected, window reads return 0 and window writes are dropped, and no existing page is reached through aliasing.
- R10: A read of the location being written in the same cycle returns the value held before the write.
- R11: The write port translates working indices in exactly the same way as the read port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dual_mode | input | 1 | 0: one 16-byte working block, 1: two 8-byte blocks |
| ptr_we | input | 1 | Load a block pointer |
| ptr_sel | input | 1 | Pointer to load: 0 for P0, 1 for P1 |
| ptr_blk | input | 5 | New pointer value, in units of 8 bytes |
| wr_en | input | 1 | Write strobe |
| wr_work | input | 1 | 1: `wr_addr[3:0]` is a working index |
| wr_addr | input | 8 | Write address or index |
| wr_data | input | 8 | Write data |
| rd_work | input | 1 | 1: `rd_addr[3:0]` is a working index |
| rd_addr | input | 8 | Read address or index |
| rd_data | output | 8 | Combinational read data |

## Verification
The assertions check four things on every cycle. The page register holds unless it is written, and it takes the written value one cycle after a write. The block pointers hold while no pointer load occurs. The window returns zero whenever an absent page is selected, and single-mode translation keeps the index as the low nibble. Only the bench scenarios can show the remaining behaviour. These cover where data actually lands under each pointer mode, that system registers are unaffected by the page, and that a page selected beyond the populated range does not alias an existing one. They also cover the one-cycle lag of a page change and reads that collide with a same-cycle write.

// File: rtl/paged_regfile.sv
module paged_regfile #(
  parameter int NPAGE = 16,
  parameter int PPW   = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dual_mode,
  input  logic       ptr_we,
  input  logic       ptr_sel,
  input  logic [4:0] ptr_blk,
  input  logic       wr_en,
  input  logic       wr_work,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       rd_work,
  input  logic [7:0] rd_addr,
  output logic [7:0] rd_data
);
  localparam logic [7:0] PAGE_REG = 8'd234;
  localparam logic [7:0] WIN_BASE = 8'd240;
  localparam int PIW = $clog2(NPAGE * 16);
  localparam int PGB = PIW - 4;
  localparam logic [PPW:0] NPG = NPAGE[PPW:0];

  logic [7:0] flat [240];
  logic [7:0] pmem [NPAGE*16];
  logic [4:0] ptr0, ptr1;
  logic [PPW-1:0] page;
  logic page_ok;
  logic [7:0] ra, wa;
  logic [PIW-1:0] rpi, wpi;

  function automatic logic [7:0] xlate(input logic work, input logic [7:0] a,
                                       input logic dual, input logic [4:0] p0,
                                       input logic [4:0] p1);
    if (!work) return a;
    if (!dual) return {p0[4:1], a[3:0]};
    return a[3] ? {p1, a[2:0]} : {p0, a[2:0]};
  endfunction

  assign ra      = xlate(rd_work, rd_addr, dual_mode, ptr0, ptr1);
  assign wa      = xlate(wr_work, wr_addr, dual_mode, ptr0, ptr1);
  assign page    = flat[PAGE_REG][PPW-1:0];
  assign page_ok = {1'b0, page} < NPG;
  assign rpi     = {page[PGB-1:0], ra[3:0]};
  assign wpi     = {page[PGB-1:0], wa[3:0]};

  always_comb begin
    if (ra >= WIN_BASE) rd_data = page_ok ? pmem[rpi] : 8'h00;
    else                rd_data = flat[ra];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr0 <= '0;
      ptr1 <= '0;
      for (int i = 0; i < 240; i++) flat[i] <= '0;
      for (int i = 0; i < NPAGE*16; i++) pmem[i] <= '0;
    end else begin
      if (ptr_we) begin
        if (ptr_sel) ptr1 <= ptr_blk;
        else         ptr0 <= ptr_blk;
      end
      if (wr_en) begin
        if (wa < WIN_BASE) flat[wa] <= wr_data;
        else if (page_ok)  pmem[wpi] <= wr_data;
      end
    end
  end

  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wa == PAGE_REG) |=> $stable(page)); // R8
  AST_PAGE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wa == PAGE_REG) |=> page == $past(wr_data[PPW-1:0])); // R7
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ptr_we |=> ($stable(ptr0) && $stable(ptr1))); // R5
  AST_ABSENT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ra >= WIN_BASE && {1'b0, page} >= NPG) |-> rd_data == 8'h00); // R9
  AST_SINGLE_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_work && !dual_mode) |-> ra[3:0] == rd_addr[3:0]); // R3
endmodule

// File: tb/tb_paged_regfile.sv
`timescale 1ns/1ps
module tb_paged_regfile;
  logic clk = 0, rst_n = 0;
  logic dual_mode = 0, ptr_we = 0, ptr_sel = 0;
  logic [4:0] ptr_blk = '0;
  logic wr_en = 0, wr_work = 0, rd_work = 0;
  logic [7:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
  logic [7:0] rd_data;
  int errors = 0, checks = 0;
  bit done = 0;

  paged_regfile dut (.clk(clk), .rst_n(rst_n), .dual_mode(dual_mode), .ptr_we(ptr_we),
    .ptr_sel(ptr_sel), .ptr_blk(ptr_blk), .wr_en(wr_en), .wr_work(wr_work),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_work(rd_work), .rd_addr(rd_addr),
    .rd_data(rd_data));

  always #5 clk = ~clk;

  // op[31:30] 0=write 1=read-check 2=pointer load; work[29] dual[28]
  // addr[27:20] data[19:12] expected[11:4] requirement number[3:0]
  localparam int NV = 31;
  localparam logic [31:0] VEC [NV] = '{
    {2'd0,1'b0,1'b0,8'd10, 8'h11,8'h00,4'd2},  // R2
    {2'd1,1'b0,1'b0,8'd10, 8'h00,8'h11,4'd2},  // R2
    {2'd2,1'b0,1'b0,8'd0,  8'd4, 8'h00,4'd5},  // R5 P0=4
    {2'd0,1'b1,1'b0,8'd3,  8'h33,8'h00,4'd11}, // R11
    {2'd1,1'b0,1'b0,8'd35, 8'h00,8'h33,4'd3},  // R3
    {2'd1,1'b1,1'b0,8'd3,  8'h00,8'h33,4'd3},  // R3
    {2'd2,1'b0,1'b0,8'd1,  8'd9, 8'h00,4'd5},  // R5 P1=9
    {2'd0,1'b1,1'b1,8'd2,  8'h44,8'h00,4'd11}, // R11
    {2'd1,1'b0,1'b0,8'd34, 8'h00,8'h44,4'd4},  // R4
    {2'd0,1'b1,1'b1,8'd10, 8'h55,8'h00,4'd4},  // R4
    {2'd1,1'b0,1'b0,8'd74, 8'h00,8'h55,4'd4},  // R4
    {2'd1,1'b1,1'b1,8'd10, 8'h00,8'h55,4'd4},  // R4
    {2'd2,1'b0,1'b0,8'd0,  8'd5, 8'h00,4'd5},  // R5 P0=5
    {2'd1,1'b1,1'b0,8'd3,  8'h00,8'h33,4'd3},  // R3 low bit ignored
    {2'd1,1'b1,1'b1,8'd3,  8'h00,8'h00,4'd4},  // R4 -> 43
    {2'd0,1'b0,1'b0,8'd230,8'h66,8'h00,4'd6},  // R6
    {2'd0,1'b0,1'b0,8'd234,8'h05,8'h00,4'd7},  // R7
    {2'd0,1'b0,1'b0,8'd242,8'h77,8'h00,4'd7},  // R7
    {2'd1,1'b0,1'b0,8'd242,8'h00,8'h77,4'd7},  // R7
    {2'd0,1'b0,1'b0,8'd234,8'h06,8'h00,4'd6},  // R6
    {2'd1,1'b0,1'b0,8'd242,8'h00,8'h00,4'd7},  // R7
    {2'd1,1'b0,1'b0,8'd230,8'h00,8'h66,4'd6},  // R6
    {2'd0,1'b0,1'b0,8'd234,8'h05,8'h00,4'd7},  // R7
    {2'd1,1'b0,1'b0,8'd242,8'h00,8'h77,4'd7},  // R7
    {2'd0,1'b0,1'b0,8'd234,8'h14,8'h00,4'd9},  // R9 page 20
    {2'd0,1'b0,1'b0,8'd245,8'h99,8'h00,4'd9},  // R9
    {2'd1,1'b0,1'b0,8'd245,8'h00,8'h00,4'd9},  // R9
    {2'd0,1'b0,1'b0,8'd234,8'h04,8'h00,4'd9},  // R9 no alias to page 4
    {2'd1,1'b0,1'b0,8'd245,8'h00,8'h00,4'd9},  // R9
    {2'd1,1'b0,1'b0,8'd234,8'h00,8'h04,4'd7},  // R7
    {2'd1,1'b1,1'b1,8'd11, 8'h00,8'h00,4'd4}   // R4 -> 75
  };

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: rd_data=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic work, input logic dual,
                       input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    dual_mode = dual; ptr_we = (op == 2'd2); ptr_sel = a[0]; ptr_blk = d[4:0];
    wr_en = (op == 2'd0); wr_work = work; wr_addr = a; wr_data = d;
    rd_work = work; rd_addr = a;
    #1;
  endtask

  task automatic rd(input logic work, input logic dual, input logic [7:0] a,
                    input logic [7:0] exp, input string req);
    drive(2'd1, work, dual, a, 8'h00);
    chk(rd_data, exp, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1 reset state
    rd(1'b0, 1'b0, 8'd0,   8'h00, "R1");
    rd(1'b0, 1'b0, 8'd234, 8'h00, "R1");
    rd(1'b0, 1'b0, 8'd242, 8'h00, "R1");
    rd(1'b1, 1'b0, 8'd0,   8'h00, "R1");
    drive(2'd0, 1'b0, 1'b0, 8'd5, 8'hA5);
    rd(1'b1, 1'b0, 8'd5,  8'hA5, "R1");  // P0 reset to 0
    rd(1'b1, 1'b1, 8'd13, 8'hA5, "R1");  // P1 reset to 0

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][31:30], VEC[i][29], VEC[i][28], VEC[i][27:20], VEC[i][19:12]);
      if (VEC[i][31:30] == 2'd1) chk(rd_data, VEC[i][11:4], $sformatf("R%0d", VEC[i][3:0]));
    end

    // R8: page write and window read in the same cycle (page is 4 here)
    drive(2'd0, 1'b0, 1'b0, 8'd234, 8'h05);
    rd_addr = 8'd242; #1;
    chk(rd_data, 8'h00, "R8");
    rd(1'b0, 1'b0, 8'd242, 8'h77, "R8");

    // R10: read of the location being written returns the old value
    drive(2'd0, 1'b0, 1'b0, 8'd10, 8'hAB);
    chk(rd_data, 8'h11, "R10");
    rd(1'b0, 1'b0, 8'd10, 8'hAB, "R10");

    // R5: pointer inputs without ptr_we change nothing
    drive(2'd0, 1'b0, 1'b0, 8'd43, 8'h5A);
    @(negedge clk);
    wr_en = 0; ptr_we = 0; ptr_sel = 0; ptr_blk = 5'd0;
    rd(1'b1, 1'b1, 8'd3, 8'h5A, "R5");

    // R1: second reset clears everything again
    @(negedge clk) rst_n = 0;
    @(negedge clk) rst_n = 1;
    rd(1'b0, 1'b0, 8'd10,  8'h00, "R1");
    rd(1'b0, 1'b0, 8'd242, 8'h00, "R1");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule